// File: doc/BRIEF.md
# Command FIFO Push Engine

This block is a hardware master that moves one command, byte by byte, into the transmit FIFO of a security-module style register window. It follows the same flow control that a host driver would use. It first waits until the device reports that it is ready for a command. It then sends the bytes in groups, and no group is larger than the burst allowance that the device advertises in its status word. The last byte is always held back and sent on its own. After that byte, the engine makes sure the device no longer expects more data. Only then does it write the start-execution bit.

Command bytes arrive on a valid/ready byte stream. A `start` pulse that carries the byte count begins each command. The engine drives a simple register master port: a status read, a byte write to the FIFO, and a word write to the status register. The read data must be valid in the same cycle the read strobe is high. The engine reports the end of a command with a `done` or `err` pulse and a reason code. Only the first locality window is used, so its base offset is 0.

Top module: `cmd_push_engine`

## Requirements
- R1: A `start` with `cmd_len` equal to 0 is rejected. `err` pulses in the next cycle with `err_code` 4, and `busy` stays low.
- R2: `busy` rises in the cycle after an accepted `start`. It stays high until the cycle in which `done` or `err` pulses, and it is low in that cycle. A `start` that arrives while `busy` is high has no effect.
- R3: Status reads always use offset 0x18. No FIFO byte is written until a status read has returned command-ready (bit 6) set. If `TMO_POLLS` consecutive reads fail to show command-ready, the command aborts with `err_code` 1.
- R4: Each FIFO write is a byte write to offset 0x24, and the bytes leave in stream order. Between two status reads, the number of FIFO writes never exceeds the burst field (bits 23:8) returned by the earlier of the two reads.
- R5: The final byte is written only when no byte has been written since the latest status read, and that read showed valid (bit 7), expect (bit 3) and a nonzero burst.
- R6: If a status read after a group of bytes shows valid set but expect clear, the command aborts with `err_code` 2 (overflow).
- R7: While the burst field reads 0, the engine keeps polling. It aborts with `err_code` 1 after `TMO_POLLS` consecutive zero reads, and the count restarts after every read that succeeds.
- R8: If the valid status read after the final byte still shows expect set, the command aborts with `err_code` 3, and the go word is never written.
- R9: After a clean final check, the engine makes exactly one word write of 0x0000_0020 (only bit 5, go) to offset 0x18. `done` pulses in the next cycle.
- R10: Any two status reads are at least `POLL_GAP` clock cycles apart.
- R11: A stream byte is consumed exactly when `in_valid` and `in_ready` are both high, and each consumed byte is exactly one FIFO write in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a command when idle |
| cmd_len | input | LEN_W | Number of command bytes, sampled with `start` |
| in_data | input | 8 | Command byte from the stream |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Engine can take a stream byte |
| bus_rd | output | 1 | Status register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_word | output | 1 | 1 = 32-bit write, 0 = byte write |
| bus_addr | output | ADDR_W | Register offset |
| bus_wdata | output | 32 | Write data (byte writes use bits 7:0) |
| bus_rdata | input | 32 | Read data, valid in the cycle `bus_rd` is high |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse: command handed over and go written |
| err | output | 1 | One-cycle pulse: command aborted |
| err_code | output | 3 | Reason: 1 timeout, 2 overflow, 3 expect stuck, 4 bad length |

## Verification
If the engine loses track of how many bytes remain, the error shows on the register port in the same cycle. A FIFO write appears with the wrong stream byte, the final byte goes out without its own status check, or the go word is written before every byte has left. If the group size is wrong, the bench sees more FIFO writes than the last burst field allowed before the next read arrives. If the poll pacing or failure counting is wrong, the reads come too close together, or the timeout lands after a different number of reads than `TMO_POLLS`. Both of these are visible within one poll interval.

// File: rtl/cmdpush_pkg.sv
`timescale 1ns/1ps
package cmdpush_pkg;

    // Register offsets inside the locality-0 window
    localparam int STS_OFFSET  = 'h18;
    localparam int FIFO_OFFSET = 'h24;

    // Status word bit positions
    localparam int BIT_VALID  = 7;
    localparam int BIT_CMDRDY = 6;
    localparam int BIT_GO     = 5;
    localparam int BIT_EXPECT = 3;
    localparam int BURST_LSB  = 8;
    localparam int BURST_W    = 16;

    localparam logic [31:0] GO_WORD = 32'h1 << BIT_GO;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT_RDY,
        S_PLAN,
        S_REFILL,
        S_FEED,
        S_WAIT_VLD,
        S_LAST,
        S_CONFIRM,
        S_GO
    } seq_state_t;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_TIMEOUT  = 3'd1,
        ERR_OVERFLOW = 3'd2,
        ERR_STUCK    = 3'd3,
        ERR_BADLEN   = 3'd4
    } fail_code_t;

    typedef struct packed {
        logic               valid;
        logic               cmd_ready;
        logic               expect_more;
        logic [BURST_W-1:0] burst;
    } sts_view_t;

    // Group size: the allowance, but never the byte that must stay back
    function automatic logic [31:0] group_size(input logic [31:0] allowance,
                                               input logic [31:0] left);
        logic [31:0] hold;
        hold = left - 32'd1;
        return (allowance < hold) ? allowance : hold;
    endfunction

endpackage

// File: rtl/cmdpush_stsdec.sv
`timescale 1ns/1ps
module cmdpush_stsdec
    import cmdpush_pkg::*;
(
    input  logic [31:0] word,
    output sts_view_t   view
);
    logic sts_unused;

    assign view.valid       = word[BIT_VALID];
    assign view.cmd_ready   = word[BIT_CMDRDY];
    assign view.expect_more = word[BIT_EXPECT];
    assign view.burst       = word[BURST_LSB +: BURST_W];
    assign sts_unused       = ^{word[31:24], word[5:4], word[2:0]};
endmodule

// File: rtl/cmdpush_pacer.sv
`timescale 1ns/1ps
module cmdpush_pacer #(
    parameter int POLL_GAP  = 200,
    parameter int TMO_POLLS = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic rd_fire,
    input  logic rd_ok,
    output logic may_poll,
    output logic last_try
);
    localparam int GAP_W  = $clog2(POLL_GAP + 1);
    localparam int FAIL_W = $clog2(TMO_POLLS + 1);
    localparam logic [GAP_W-1:0]  GAP_RELOAD = GAP_W'(POLL_GAP - 1);
    localparam logic [GAP_W-1:0]  GAP_ONE    = GAP_W'(1);
    localparam logic [FAIL_W-1:0] FAIL_LAST  = FAIL_W'(TMO_POLLS - 1);
    localparam logic [FAIL_W-1:0] FAIL_ONE   = FAIL_W'(1);

    logic [GAP_W-1:0]  gap_q;
    logic [FAIL_W-1:0] fail_q;

    // Spacing between any two reads, independent of sequencer state
    always_ff @(posedge clk) begin
        if (rst)                gap_q <= '0;
        else if (rd_fire)       gap_q <= GAP_RELOAD;
        else if (gap_q != '0)   gap_q <= gap_q - GAP_ONE;
    end

    // Consecutive unsuccessful reads
    always_ff @(posedge clk) begin
        if (rst || restart)     fail_q <= '0;
        else if (rd_fire)       fail_q <= rd_ok ? '0 : fail_q + FAIL_ONE;
    end

    assign may_poll = (gap_q == '0);
    assign last_try = (fail_q == FAIL_LAST);

    // R10
    poll_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (gap_q != '0) |-> !rd_fire);
endmodule

// File: rtl/cmdpush_seq.sv
`timescale 1ns/1ps
module cmdpush_seq
    import cmdpush_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  sts_view_t         sts,
    input  logic              may_poll,
    input  logic              last_try,
    output logic              pace_restart,
    output logic              rd_ok,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_code
);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(STS_OFFSET);
    localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(FIFO_OFFSET);
    localparam logic [LEN_W-1:0]  L_ONE  = LEN_W'(1);

    seq_state_t        state_q, state_d;
    logic [LEN_W-1:0]  left_q, left_d;
    logic [LEN_W-1:0]  group_q, group_d;
    logic [BURST_W-1:0] allow_q, allow_d;
    fail_code_t        code_q, code_d;
    logic              done_d, err_d, done_q, err_q;

    always_comb begin
        state_d      = state_q;
        left_d       = left_q;
        group_d      = group_q;
        allow_d      = allow_q;
        code_d       = code_q;
        done_d       = 1'b0;
        err_d        = 1'b0;
        bus_rd       = 1'b0;
        bus_wr       = 1'b0;
        bus_word     = 1'b0;
        bus_addr     = A_STS;
        bus_wdata    = '0;
        in_ready     = 1'b0;
        rd_ok        = 1'b0;
        pace_restart = 1'b0;
        unique case (state_q)
            S_IDLE: if (start) begin
                code_d = ERR_NONE;
                if (cmd_len == '0) begin
                    err_d  = 1'b1;
                    code_d = ERR_BADLEN;
                end else begin
                    left_d       = cmd_len;
                    pace_restart = 1'b1;
                    state_d      = S_WAIT_RDY;
                end
            end
            S_WAIT_RDY, S_REFILL, S_WAIT_VLD, S_CONFIRM: begin
                bus_rd = may_poll;
                rd_ok  = (state_q == S_WAIT_RDY) ? sts.cmd_ready :
                         (state_q == S_REFILL)   ? (sts.burst != '0) : sts.valid;
                if (bus_rd && rd_ok) begin
                    unique case (state_q)
                        S_WAIT_RDY, S_REFILL: begin
                            allow_d = sts.burst;
                            state_d = S_PLAN;
                        end
                        S_WAIT_VLD: begin
                            if (!sts.expect_more) begin
                                err_d   = 1'b1;
                                code_d  = ERR_OVERFLOW;
                                state_d = S_IDLE;
                            end else begin
                                allow_d = sts.burst;
                                state_d = (left_q == L_ONE && sts.burst != '0) ? S_LAST : S_PLAN;
                            end
                        end
                        default: begin
                            if (sts.expect_more) begin
                                err_d   = 1'b1;
                                code_d  = ERR_STUCK;
                                state_d = S_IDLE;
                            end else begin
                                state_d = S_GO;
                            end
                        end
                    endcase
                end else if (bus_rd && last_try) begin
                    err_d   = 1'b1;
                    code_d  = ERR_TIMEOUT;
                    state_d = S_IDLE;
                end
            end
            S_PLAN: begin
                if (allow_q == '0) begin
                    state_d = S_REFILL;
                end else begin
                    group_d = LEN_W'(group_size(32'(allow_q), 32'(left_q)));
                    state_d = (group_d == '0) ? S_WAIT_VLD : S_FEED;
                end
            end
            S_FEED, S_LAST: begin
                in_ready  = 1'b1;
                bus_wr    = in_valid;
                bus_addr  = A_FIFO;
                bus_wdata = {24'b0, in_data};
                if (in_valid) begin
                    left_d  = left_q - L_ONE;
                    group_d = group_q - L_ONE;
                    if (state_q == S_LAST)        state_d = S_CONFIRM;
                    else if (group_q == L_ONE)    state_d = S_WAIT_VLD;
                end
            end
            S_GO: begin
                bus_wr    = 1'b1;
                bus_word  = 1'b1;
                bus_wdata = GO_WORD;
                done_d    = 1'b1;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            left_q  <= '0;
            group_q <= '0;
            allow_q <= '0;
            code_q  <= ERR_NONE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            group_q <= group_d;
            allow_q <= allow_d;
            code_q  <= code_d;
            done_q  <= done_d;
            err_q   <= err_d;
        end
    end

    assign busy     = (state_q != S_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign err_code = code_q;

    // R1
    badlen_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && cmd_len == '0) |=> (err && err_code == ERR_BADLEN && !busy));
    // R2
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> !busy);
    // R4
    data_needs_bytes_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_word) |-> (left_q != '0));
    // R6
    overflow_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT_VLD && bus_rd && sts.valid && !sts.expect_more)
        |=> (err && err_code == ERR_OVERFLOW));
    // R8
    stuck_expect_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_CONFIRM && bus_rd && sts.valid && sts.expect_more)
        |=> (err && err_code == ERR_STUCK && !bus_wr));
    // R9
    go_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word) |=> (done && !busy));
endmodule

// File: rtl/cmd_push_engine.sv
`timescale 1ns/1ps
module cmd_push_engine
    import cmdpush_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int LEN_W     = 12,
    parameter int POLL_GAP  = 200,
    parameter int TMO_POLLS = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_code
);
    sts_view_t sts;
    logic      may_poll, last_try, pace_restart, rd_ok;

    cmdpush_stsdec u_dec (
        .word (bus_rdata),
        .view (sts)
    );

    cmdpush_pacer #(.POLL_GAP(POLL_GAP), .TMO_POLLS(TMO_POLLS)) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .restart  (pace_restart),
        .rd_fire  (bus_rd),
        .rd_ok    (rd_ok),
        .may_poll (may_poll),
        .last_try (last_try)
    );

    cmdpush_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cmd_len      (cmd_len),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .sts          (sts),
        .may_poll     (may_poll),
        .last_try     (last_try),
        .pace_restart (pace_restart),
        .rd_ok        (rd_ok),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_word     (bus_word),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .busy         (busy),
        .done         (done),
        .err          (err),
        .err_code     (err_code)
    );
endmodule

// File: tb/cmd_push_engine_test.sv
`timescale 1ns/1ps
module cmd_push_engine_test;
    localparam int ADDR_W    = 12;
    localparam int LEN_W     = 8;
    localparam int POLL_GAP  = 3;
    localparam int TMO_POLLS = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [7:0]        in_data = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              bus_rd, bus_wr, bus_word;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata = '0;
    logic              busy, done, err;
    logic [2:0]        err_code;

    cmd_push_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .POLL_GAP(POLL_GAP),
                      .TMO_POLLS(TMO_POLLS)) uut (
        .clk(clk), .rst(rst), .start(start), .cmd_len(cmd_len),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .err(err), .err_code(err_code));

    always #2.5 clk = ~clk;

    int tests = 0;
    int fails = 0;

    // device model
    int cmdrdy_after, exp_total, rx_count, dflt_burst, reads, go_writes;
    int wr_since_rd, budget, since_rd, cur_len, src_idx, stall_mode, cyc;
    int bq[$];
    logic [7:0] src[$];
    logic [7:0] rx[$];
    logic [31:0] last_rd;
    bit seen_rdy, inflight, got_done, got_err;
    logic [2:0] got_code;
    // captured bus activity, applied at the following negedge
    bit cap_rd, cap_wr, cap_go;
    logic [31:0] cap_rdata;
    logic [7:0]  cap_byte;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] status_word();
        logic [15:0] b;
        b = (bq.size() > 0) ? 16'(bq[0]) : 16'(dflt_burst);
        return {8'h00, b, 1'b1, (reads >= cmdrdy_after), 2'b00,
                (rx_count < exp_total), 3'b000};
    endfunction

    task automatic monitor();
        since_rd++;
        if (bus_rd) begin
            chk(since_rd >= POLL_GAP, "R10", "read spacing", since_rd, POLL_GAP);
            chk(bus_addr == 12'h018, "R3", "status read offset", bus_addr, 'h18);
            since_rd = 0;
            cap_rd = 1; cap_rdata = bus_rdata;
        end
        if (bus_wr && !bus_word) begin
            chk(bus_addr == 12'h024, "R4", "fifo offset", bus_addr, 'h24);
            chk(in_valid && in_ready, "R11", "write without handshake", in_ready, 1);
            chk(seen_rdy, "R3", "byte before command-ready", 0, 1);
            chk(wr_since_rd < budget, "R4", "writes beyond burst", wr_since_rd + 1, budget);
            if (src_idx < src.size())
                chk(bus_wdata[7:0] == src[src_idx], "R4", "byte order", bus_wdata[7:0], src[src_idx]);
            if (src_idx == cur_len - 1) begin
                chk(wr_since_rd == 0, "R5", "writes before final byte since read", wr_since_rd, 0);
                chk(last_rd[7] && last_rd[3] && last_rd[23:8] != 0, "R5",
                    "status before final byte", last_rd, 'h88);
            end
            cap_wr = 1; cap_byte = bus_wdata[7:0];
        end else if (in_valid && in_ready) begin
            chk(0, "R11", "handshake without write", 0, 1);
        end
        if (bus_wr && bus_word) begin
            chk(bus_addr == 12'h018 && bus_wdata == 32'h20, "R9", "go word",
                bus_wdata, 'h20);
            chk(src_idx == cur_len, "R9", "go before all bytes", src_idx, cur_len);
            chk(last_rd[7] && !last_rd[3], "R9", "go without clean check", last_rd, 'h80);
            cap_go = 1;
        end
        if (inflight && !(done || err))
            chk(busy, "R2", "busy during command", busy, 1);
        if (done || err) begin
            chk(!busy, "R2", "busy with end pulse", busy, 0);
            got_done = done; got_err = err; got_code = err_code;
            inflight = 0;
        end
    endtask

    // per-cycle device and stream model
    initial begin
        since_rd = 1000; cyc = 0;
        forever begin
            @(negedge clk);
            if (cap_rd) begin
                reads++; last_rd = cap_rdata; wr_since_rd = 0;
                budget = int'(cap_rdata[23:8]);
                if (cap_rdata[6]) seen_rdy = 1;
                if (bq.size() > 0) void'(bq.pop_front());
            end
            if (cap_wr) begin
                rx.push_back(cap_byte); rx_count++; src_idx++; wr_since_rd++;
            end
            if (cap_go) go_writes++;
            cap_rd = 0; cap_wr = 0; cap_go = 0;
            bus_rdata = status_word();
            in_valid  = (src_idx < src.size()) && (stall_mode == 0 || cyc[0]);
            in_data   = (src_idx < src.size()) ? src[src_idx] : 8'h00;
            cyc++;
            #1;
            if (!rst) monitor();
        end
    end

    task automatic setup(input int len, input int rdy_after, input int total,
                         input int burst, input int stall);
        src.delete(); rx.delete(); bq.delete();
        for (int i = 0; i < len; i++) src.push_back(8'((i * 37 + 11) & 255));
        cur_len = len; cmdrdy_after = rdy_after; exp_total = total;
        dflt_burst = burst; stall_mode = stall;
        reads = 0; rx_count = 0; go_writes = 0; src_idx = 0;
        wr_since_rd = 0; budget = 0; last_rd = 0; seen_rdy = 0;
        got_done = 0; got_err = 0; got_code = 0;
    endtask

    task automatic launch(input int len);
        @(negedge clk);
        start = 1; cmd_len = LEN_W'(len);
        @(negedge clk);
        start = 0;
        inflight = (len != 0);
    endtask

    task automatic finish_wait();
        int n;
        n = 0;
        while (!(got_done || got_err) && n < 5000) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic rx_matches(input string req);
        bit ok;
        ok = (rx.size() <= src.size());
        for (int i = 0; i < rx.size() && ok; i++) if (rx[i] != src[i]) ok = 0;
        chk(ok, req, "received bytes differ from stream", rx.size(), src.size());
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++; tests++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
        summary();
    end

    initial begin
        setup(0, 0, 0, 4, 0);
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        // R2 reset state
        chk(!busy && !done && !err, "R2", "reset flags", {busy, done, err}, 0);
        chk(!bus_rd && !bus_wr && !in_ready, "R2", "reset bus idle", {bus_rd, bus_wr, in_ready}, 0);

        // R9 R4 normal command, ready after two polls
        setup(10, 2, 10, 4, 0);
        launch(10); finish_wait();
        chk(got_done && !got_err, "R9", "normal done", got_err, 0);
        chk(rx.size() == 10, "R4", "normal byte count", rx.size(), 10);
        rx_matches("R4");
        chk(go_writes == 1, "R9", "go writes", go_writes, 1);

        // R5 single byte command
        setup(1, 0, 1, 4, 0);
        launch(1); finish_wait();
        chk(got_done && rx.size() == 1, "R5", "one-byte command", rx.size(), 1);
        rx_matches("R5");

        // R7 R11 zero bursts and stalling stream
        setup(7, 0, 7, 3, 1);
        bq = '{0, 0, 0, 2, 0, 0, 5};
        launch(7); finish_wait();
        chk(got_done && !got_err, "R7", "refill then done", got_code, 0);
        chk(rx.size() == 7, "R11", "stalled stream byte count", rx.size(), 7);
        rx_matches("R11");

        // R7 burst never opens
        setup(5, 0, 5, 0, 0);
        launch(5); finish_wait();
        chk(got_err && got_code == 3'd1, "R7", "refill timeout code", got_code, 1);
        chk(reads == 1 + TMO_POLLS, "R7", "refill timeout reads", reads, 1 + TMO_POLLS);
        chk(rx.size() == 0, "R7", "no bytes on refill timeout", rx.size(), 0);

        // R3 command-ready never set
        setup(5, 1000, 5, 4, 0);
        launch(5); finish_wait();
        chk(got_err && got_code == 3'd1, "R3", "ready timeout code", got_code, 1);
        chk(reads == TMO_POLLS, "R3", "ready timeout reads", reads, TMO_POLLS);
        chk(rx.size() == 0, "R3", "no bytes before ready", rx.size(), 0);

        // R6 device stops expecting early
        setup(6, 0, 3, 8, 0);
        launch(6); finish_wait();
        chk(got_err && got_code == 3'd2, "R6", "overflow code", got_code, 2);
        chk(rx.size() == 5, "R6", "bytes before overflow", rx.size(), 5);
        chk(go_writes == 0, "R6", "no go on overflow", go_writes, 0);

        // R8 device still expects after final byte
        setup(5, 0, 20, 8, 0);
        launch(5); finish_wait();
        chk(got_err && got_code == 3'd3, "R8", "stuck expect code", got_code, 3);
        chk(go_writes == 0, "R8", "no go when expect stuck", go_writes, 0);
        chk(rx.size() == 5, "R8", "all bytes sent", rx.size(), 5);

        // R1 zero length
        setup(0, 0, 0, 4, 0);
        launch(0);
        #1;
        chk(err && err_code == 3'd4, "R1", "bad length pulse", err_code, 4);
        chk(!busy, "R1", "busy on bad length", busy, 0);
        @(negedge clk); #1;
        chk(!busy && !err, "R1", "idle after bad length", busy, 0);

        // R2 start during a command is ignored
        setup(10, 1, 10, 2, 0);
        launch(10);
        repeat (4) @(negedge clk);
        start = 1; cmd_len = '0;
        @(negedge clk);
        start = 0;
        finish_wait();
        chk(got_done && !got_err, "R2", "start while busy ignored", got_err, 0);
        chk(rx.size() == 10, "R2", "bytes after ignored start", rx.size(), 10);
        rx_matches("R2");

        summary();
    end
endmodule